// File: doc/BRIEF.md
# LDPC Bit-Node Update Unit

This block performs the variable-node step of an iterative soft LDPC decoder for a single bit of the codeword. It takes the channel log-likelihood ratio of that bit and the messages arriving from each of its `N_EDGE` attached parity checks. From these it forms three results:

- the a-posteriori LLR, which is the channel value plus every incoming message;
- a hard bit decision taken from the sign of the a-posteriori LLR;
- one outgoing message per edge, equal to the a-posteriori LLR minus the message that arrived on that same edge, clamped back to message width.

A build parameter selects one of two implementations. The concurrent build accepts all edge messages in a single cycle. An adder tree sums them, and one subtract-and-clamp unit per edge forms every outgoing message, so all results appear together one cycle later. The sequential build stores the channel value in an accumulator and then takes one edge message per accepted cycle, keeping a copy of each in a small register file. After the last message it streams one outgoing message per cycle, in edge order. The sequential build works for any edge count at the cost of roughly 2·`N_EDGE` cycles per node.

Message routing between nodes and the decision of when to stop iterating are handled outside this block.

Top module: `ldpc_bitnode`

## Requirements
- R1: `post_llr` equals the signed sum of `chan_llr` and all `N_EDGE` incoming messages. It is `MSG_W + ceil(log2(N_EDGE+1))` bits wide and never overflows.
- R2: The outgoing message for edge i equals `post_llr` minus the incoming message of edge i. Lane i occupies bits `[i*MSG_W +: MSG_W]` of `msg_in` and `msg_out`.
- R3: An outgoing message whose exact value lies outside the two's-complement message range is clamped: to `2^(MSG_W-1)-1` when too large, and to `-2^(MSG_W-1)` when too small.
- R4: `hard_bit` is 1 when `post_llr` is negative and 0 otherwise, including when `post_llr` is exactly zero.
- R5: Concurrent build (`SERIAL=0`): a cycle with both `start` and `in_valid` high captures `chan_llr` and all lanes of `msg_in`. `out_valid` and `done` are then high for exactly the next cycle, with all lanes, `post_llr` and `hard_bit` valid together.
- R6: Concurrent build: `start` without `in_valid`, or `in_valid` without `start`, starts nothing. No `out_valid` follows, and `post_llr` keeps the value of the previous job.
- R7: Sequential build (`SERIAL=1`): an idle cycle with `start` high loads `chan_llr`. The next `N_EDGE` cycles with `in_valid` high supply edge messages 0, 1, … on lane 0 of `msg_in`. Cycles with `in_valid` low are skipped.
- R8: Sequential build: starting the cycle after the last message is accepted, `out_valid` stays high for `N_EDGE` consecutive cycles. Lane 0 of `msg_out` carries the outgoing messages for edges 0 through `N_EDGE-1` in that order, with `post_llr` and `hard_bit` valid throughout. All other lanes read zero.
- R9: Sequential build: `done` is high only during the last of those `N_EDGE` output cycles.
- R10: Sequential build: `start` while a node is loading or emitting is ignored, and `in_valid` while idle or emitting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a node job |
| in_valid | input | 1 | Edge message(s) present on `msg_in` |
| chan_llr | input | MSG_W | Channel LLR, two's complement |
| msg_in | input | N_EDGE*MSG_W | Incoming check-to-bit messages (lane 0 only in sequential build) |
| out_valid | output | 1 | Outgoing message(s) valid |
| done | output | 1 | Last output of the job |
| msg_out | output | N_EDGE*MSG_W | Outgoing bit-to-check messages |
| post_llr | output | MSG_W+ceil(log2(N_EDGE+1)) | A-posteriori LLR |
| hard_bit | output | 1 | Hard decision (1 when negative) |

## Verification
In the concurrent build every result is registered once. A job driven on one edge therefore shows `out_valid`, all lanes, `post_llr` and `hard_bit` in the cycle right after it, and `done` appears in that same cycle. In the sequential build the first outgoing message is due in the cycle after the clock edge that accepts the `N_EDGE`-th incoming message. One message then follows per cycle, and `done` coincides with the last. The bench drives inputs on the falling edge and samples outputs on the falling edge. It queues one expected item for each cycle in which the design should present an output, and pops an item only when `out_valid` is seen. A result that arrives early, arrives late, or has no matching expectation is therefore caught, including an output triggered by stimulus that should have been ignored.

// File: rtl/bnp_pkg.sv
package bnp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_EMIT = 2'd2
    } bnp_phase_e;

    function automatic int guard_bits(input int edges);
        return $clog2(edges + 1);
    endfunction

endpackage

// File: rtl/bnp_sub_sat.sv
module bnp_sub_sat #(
    parameter int MSG_W = 4,
    parameter int ACC_W = 7
) (
    input  logic signed [ACC_W-1:0] total,
    input  logic signed [MSG_W-1:0] own_msg,
    output logic signed [MSG_W-1:0] result
);
    localparam int DIF_W = ACC_W + 1;
    localparam logic signed [DIF_W-1:0] HI = DIF_W'((1 <<< (MSG_W - 1)) - 1);
    localparam logic signed [DIF_W-1:0] LO = -DIF_W'(1 <<< (MSG_W - 1));

    logic signed [DIF_W-1:0] diff;

    always_comb begin
        diff = DIF_W'(total) - DIF_W'(own_msg);
        if (diff > HI)      result = HI[MSG_W-1:0];
        else if (diff < LO) result = LO[MSG_W-1:0];
        else                result = diff[MSG_W-1:0];
    end
endmodule

// File: rtl/bnp_par_core.sv
module bnp_par_core #(
    parameter int MSG_W  = 4,
    parameter int N_EDGE = 4,
    parameter int ACC_W  = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fire,
    input  logic [MSG_W-1:0]           chan,
    input  logic [N_EDGE*MSG_W-1:0]    msgs,
    output logic [ACC_W-1:0]           post_q,
    output logic [N_EDGE*MSG_W-1:0]    lanes_q,
    output logic                       vld_q
);
    logic signed [ACC_W-1:0]        total;
    logic        [N_EDGE*MSG_W-1:0] lanes_d;

    always_comb begin
        total = ACC_W'($signed(chan));
        for (int i = 0; i < N_EDGE; i++) begin
            total = total + ACC_W'($signed(msgs[i*MSG_W +: MSG_W]));
        end
    end

    for (genvar g = 0; g < N_EDGE; g++) begin : g_lane
        bnp_sub_sat #(.MSG_W(MSG_W), .ACC_W(ACC_W)) u_sub (
            .total   (total),
            .own_msg (msgs[g*MSG_W +: MSG_W]),
            .result  (lanes_d[g*MSG_W +: MSG_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            post_q  <= '0;
            lanes_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= fire;
            if (fire) begin
                post_q  <= total;
                lanes_q <= lanes_d;
            end
        end
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (rst) fire |=> vld_q);
    p_no_event_r6: assert property (@(posedge clk) disable iff (rst) !fire |=> !vld_q);
    p_hold_post_r6: assert property (@(posedge clk) disable iff (rst) !fire |=> $stable(post_q));
endmodule

// File: rtl/bnp_ser_core.sv
module bnp_ser_core
    import bnp_pkg::*;
#(
    parameter int MSG_W  = 4,
    parameter int N_EDGE = 4,
    parameter int ACC_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             in_valid,
    input  logic [MSG_W-1:0] chan,
    input  logic [MSG_W-1:0] msg,
    output logic [ACC_W-1:0] post,
    output logic [MSG_W-1:0] lane,
    output logic             vld,
    output logic             last
);
    localparam int CNT_W = $clog2(N_EDGE + 1);
    localparam int IDX_W = (N_EDGE > 1) ? $clog2(N_EDGE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_EDGE - 1);

    bnp_phase_e              phase;
    logic signed [ACC_W-1:0] acc;
    logic [CNT_W-1:0]        cnt;
    logic [IDX_W-1:0]        idx;
    logic signed [MSG_W-1:0] store [N_EDGE];

    assign idx = cnt[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            acc   <= '0;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    acc   <= ACC_W'($signed(chan));
                    cnt   <= '0;
                    phase <= PH_LOAD;
                end
                PH_LOAD: if (in_valid) begin
                    acc <= acc + ACC_W'($signed(msg));
                    if (cnt == CNT_LAST) begin
                        cnt   <= '0;
                        phase <= PH_EMIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_EMIT: begin
                    if (cnt == CNT_LAST) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (phase == PH_LOAD && in_valid) store[idx] <= msg;
    end

    bnp_sub_sat #(.MSG_W(MSG_W), .ACC_W(ACC_W)) u_sub (
        .total   (acc),
        .own_msg (store[idx]),
        .result  (lane)
    );

    assign post = acc;
    assign vld  = (phase == PH_EMIT);
    assign last = (phase == PH_EMIT) && (cnt == CNT_LAST);

    p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && !in_valid) |=> $stable(acc));
    p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EMIT && start) |=> (phase != PH_LOAD));
    p_emit_run_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EMIT && cnt != CNT_LAST) |=> (phase == PH_EMIT));
    p_emit_acc_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EMIT) |=> $stable(acc));
endmodule

// File: rtl/ldpc_bitnode.sv
module ldpc_bitnode
    import bnp_pkg::*;
#(
    parameter int MSG_W  = 4,
    parameter int N_EDGE = 4,
    parameter bit SERIAL = 1'b0,
    localparam int ACC_W = MSG_W + guard_bits(N_EDGE)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    in_valid,
    input  logic [MSG_W-1:0]        chan_llr,
    input  logic [N_EDGE*MSG_W-1:0] msg_in,
    output logic                    out_valid,
    output logic                    done,
    output logic [N_EDGE*MSG_W-1:0] msg_out,
    output logic [ACC_W-1:0]        post_llr,
    output logic                    hard_bit
);
    if (SERIAL) begin : g_seq
        logic [MSG_W-1:0] lane0;
        bnp_ser_core #(.MSG_W(MSG_W), .N_EDGE(N_EDGE), .ACC_W(ACC_W)) u_core (
            .clk      (clk),
            .rst      (rst),
            .start    (start),
            .in_valid (in_valid),
            .chan     (chan_llr),
            .msg      (msg_in[MSG_W-1:0]),
            .post     (post_llr),
            .lane     (lane0),
            .vld      (out_valid),
            .last     (done)
        );
        assign msg_out = {{((N_EDGE-1)*MSG_W){1'b0}}, lane0};
    end else begin : g_conc
        logic fire;
        assign fire = start & in_valid;
        bnp_par_core #(.MSG_W(MSG_W), .N_EDGE(N_EDGE), .ACC_W(ACC_W)) u_core (
            .clk     (clk),
            .rst     (rst),
            .fire    (fire),
            .chan    (chan_llr),
            .msgs    (msg_in),
            .post_q  (post_llr),
            .lanes_q (msg_out),
            .vld_q   (out_valid)
        );
        assign done = out_valid;
    end

    assign hard_bit = post_llr[ACC_W-1];

    p_done_in_valid_r9: assert property (@(posedge clk) disable iff (rst) done |-> out_valid);
endmodule

// File: tb/ldpc_bitnode_tb.sv
module ldpc_bitnode_tb;
    localparam int MW = 4;
    localparam int NE = 4;
    localparam int AW = MW + $clog2(NE + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          p_start = 0, p_inv = 0;
    logic [MW-1:0] p_chan = '0;
    logic [NE*MW-1:0] p_min = '0;
    logic          p_ov, p_done, p_hb;
    logic [NE*MW-1:0] p_mout;
    logic [AW-1:0] p_post;

    logic          s_start = 0, s_inv = 0;
    logic [MW-1:0] s_chan = '0;
    logic [NE*MW-1:0] s_min = '0;
    logic          s_ov, s_done, s_hb;
    logic [NE*MW-1:0] s_mout;
    logic [AW-1:0] s_post;

    ldpc_bitnode #(.MSG_W(MW), .N_EDGE(NE), .SERIAL(1'b0)) u_dut (
        .clk(clk), .rst(rst), .start(p_start), .in_valid(p_inv), .chan_llr(p_chan),
        .msg_in(p_min), .out_valid(p_ov), .done(p_done), .msg_out(p_mout),
        .post_llr(p_post), .hard_bit(p_hb));

    ldpc_bitnode #(.MSG_W(MW), .N_EDGE(NE), .SERIAL(1'b1)) u_ser (
        .clk(clk), .rst(rst), .start(s_start), .in_valid(s_inv), .chan_llr(s_chan),
        .msg_in(s_min), .out_valid(s_ov), .done(s_done), .msg_out(s_mout),
        .post_llr(s_post), .hard_bit(s_hb));

    typedef struct { int post; bit hb; int lane [NE]; } par_exp_t;
    typedef struct { int post; bit hb; int msg; bit last; } ser_exp_t;
    par_exp_t pq[$];
    ser_exp_t sq[$];

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int last_par_post = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int clampm(input int v);
        if (v > 7) return 7;
        if (v < -8) return -8;
        return v;
    endfunction

    function automatic int s4(input logic [MW-1:0] v);
        return int'($signed(v));
    endfunction

    // scoreboard monitor: concurrent build
    always @(negedge clk) begin
        if (!rst && p_ov) begin
            if (pq.size() == 0) begin
                chk(1'b0, "R6 output without a job", 1, 0);
            end else begin
                par_exp_t e;
                e = pq.pop_front();
                chk(int'($signed(p_post)) == e.post, "R1 post_llr", int'($signed(p_post)), e.post);
                chk(p_hb == e.hb, "R4 hard_bit", p_hb, e.hb);
                chk(p_done == 1'b1, "R5 done with out_valid", p_done, 1);
                for (int i = 0; i < NE; i++)
                    chk(s4(p_mout[i*MW +: MW]) == e.lane[i], "R2/R3 lane", s4(p_mout[i*MW +: MW]), e.lane[i]);
            end
        end
    end

    // scoreboard monitor: sequential build
    always @(negedge clk) begin
        if (!rst && s_ov) begin
            if (sq.size() == 0) begin
                chk(1'b0, "R10 output without a job", 1, 0);
            end else begin
                ser_exp_t e;
                e = sq.pop_front();
                chk(int'($signed(s_post)) == e.post, "R1/R8 post_llr", int'($signed(s_post)), e.post);
                chk(s_hb == e.hb, "R4 hard_bit", s_hb, e.hb);
                chk(s4(s_mout[MW-1:0]) == e.msg, "R8 lane0 message", s4(s_mout[MW-1:0]), e.msg);
                chk(s_mout[NE*MW-1:MW] == '0, "R8 upper lanes zero", int'(s_mout[NE*MW-1:MW]), 0);
                chk(s_done == e.last, "R9 done on last", s_done, e.last);
            end
        end else if (!rst && s_done) begin
            chk(1'b0, "R9 done without out_valid", 1, 0);
        end
    end

    task automatic par_job(input int ch, input int m0, input int m1, input int m2, input int m3);
        int m [NE];
        par_exp_t e;
        m = '{m0, m1, m2, m3};
        e.post = ch;
        for (int i = 0; i < NE; i++) e.post += m[i];
        e.hb = (e.post < 0);
        for (int i = 0; i < NE; i++) e.lane[i] = clampm(e.post - m[i]);
        @(negedge clk);
        p_start = 1; p_inv = 1; p_chan = MW'(ch);
        for (int i = 0; i < NE; i++) p_min[i*MW +: MW] = MW'(m[i]);
        pq.push_back(e);
        last_par_post = e.post;
        @(negedge clk);
        p_start = 0; p_inv = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ser_job(input int ch, input int m0, input int m1, input int m2, input int m3,
                           input bit gaps, input bit stray);
        int m [NE];
        int tot;
        m = '{m0, m1, m2, m3};
        tot = ch;
        for (int i = 0; i < NE; i++) tot += m[i];
        for (int i = 0; i < NE; i++) begin
            ser_exp_t e;
            e.post = tot; e.hb = (tot < 0); e.msg = clampm(tot - m[i]); e.last = (i == NE - 1);
            sq.push_back(e);
        end
        @(negedge clk);
        s_start = 1; s_chan = MW'(ch);
        for (int i = 0; i < NE; i++) begin
            @(negedge clk);
            s_start = 0; s_inv = 0;
            if (gaps) begin
                s_inv = 0; s_min = '1;
                if (stray) begin s_start = 1; s_chan = 4'd7; end
                @(negedge clk);
                s_start = 0;
            end
            s_inv = 1; s_min = '0; s_min[MW-1:0] = MW'(m[i]);
        end
        @(negedge clk);
        s_inv = 0;
        for (int i = 0; i < NE + 2; i++) begin
            if (stray && i < NE) begin
                s_inv = 1; s_start = 1; s_min = '1; s_chan = 4'd5;
            end else begin
                s_inv = 0; s_start = 0;
            end
            @(negedge clk);
        end
        s_inv = 0; s_start = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(p_ov == 0, "R5 reset out_valid", p_ov, 0);
        chk(p_done == 0, "R5 reset done", p_done, 0);
        chk(s_ov == 0, "R8 reset out_valid", s_ov, 0);
        chk(s_done == 0, "R9 reset done", s_done, 0);

        // concurrent build
        par_job(3, 1, 2, -1, 0);
        par_job(7, 7, 7, 7, 7);       // R3 upper clamp
        par_job(-8, -8, -8, -8, -8);  // R3 lower clamp, R1 full range
        par_job(2, -2, 1, -1, 0);     // R4 zero decides 0
        par_job(-3, 1, 0, 0, -1);
        // R6: lone start, then lone in_valid
        @(negedge clk); p_start = 1; p_chan = 4'd6; p_min = '1;
        @(negedge clk); p_start = 0; p_inv = 1;
        @(negedge clk); p_inv = 0;
        repeat (2) @(negedge clk);
        chk(int'($signed(p_post)) == last_par_post, "R6 post_llr held", int'($signed(p_post)), last_par_post);

        // sequential build
        ser_job(3, 1, 2, -1, 0, 0, 0);
        ser_job(7, 7, 7, 7, 7, 1, 0);       // R7 gaps
        ser_job(-8, -8, -8, -8, -8, 1, 1);  // R10 stray start while loading
        ser_job(2, -2, 1, -1, 0, 0, 1);     // R10 stray in_valid/start while emitting
        ser_job(-3, 1, 0, 0, -1, 0, 0);
        // R10: in_valid while idle
        @(negedge clk); s_inv = 1; s_min = '1;
        @(negedge clk); s_inv = 0;
        repeat (3) @(negedge clk);

        chk(pq.size() == 0, "R5 concurrent jobs all answered", pq.size(), 0);
        chk(sq.size() == 0, "R8 sequential outputs all seen", sq.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule